// File: doc/BRIEF.md
# Real-Time Clock Interrupt Controller

This block raises interrupts for a real-time clock from three independent sources. A countdown timer counts a selectable prescaler strobe: 4096 Hz, 64 Hz, once per second or once per minute. It reloads from a 12-bit value each time it expires. An update source fires on every second strobe or on every minute strobe. An alarm source compares the minute, hour and day the host has stored against the running calendar. The day can be matched as a date or as a weekday.

Each source has a sticky flag. A flag is set by its event and cleared only by a one-cycle clear strobe, which stands for the host writing 0 to it. The block drives an open-drain interrupt line, modelled here by `int_low`. When `int_low` is 1 the pin is pulled low; when it is 0 the pin is released. Timer and update events with their enable set pull the line low for a fixed number of 4096 Hz strobes, 32 by default (about 7.8 ms). After that the line releases even though the flag stays set. An alarm holds the line low for as long as its flag and its enable are both set.

The block takes decoded control fields and prescaler strobes as inputs. It does no register decoding and has no bus interface.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset all three flags read 0 and `int_low` is 0.
- R2: The timer advances only on the strobe picked by `tmr_src` (0 = `tick_4k`, 1 = `tick_64`, 2 = `tick_sec`, 3 = `tick_min`) and only while `tmr_en` is 1. While `tmr_en` is 0 its count is reloaded from `tmr_reload` every cycle.
- R3: With `tmr_en` high, the timer expires on the Nth selected strobe, where N is `tmr_reload`. A reload of 0 behaves as 1. On expiry the count reloads and counting continues. Each expiry sets `tf_flag` on the next clock edge.
- R4: An update event occurs on `tick_sec` when `upd_min_mode` is 0 and on `tick_min` when it is 1. Each update event sets `uf_flag` on the next edge.
- R5: The alarm matches when every enabled field equals the calendar. The fields are minute, hour and day. The day field compares `alm_day` with `cal_date`, or `alm_day[2:0]` with `cal_wday` when `alm_wday_mode` is 1. With no field enabled the alarm never matches. `af_flag` is set on the cycle a match begins (a rising edge of the match condition).
- R6: Each flag stays set until its clear strobe is applied. A clear in the same cycle as a new event leaves the flag set.
- R7: A timer event while `tmr_ie` is 1, or an update event while `upd_ie` is 1, makes `int_low` 1 from the next edge. It stays 1 until PULSE_TICKS further `tick_4k` strobes have been seen. A new such event restarts the count. Clearing the flag does not shorten the pulse.
- R8: A timer or update event whose enable is 0 sets its flag but does not drive `int_low`.
- R9: While `af_flag` and `alm_ie` are both 1, `int_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_4k | input | 1 | One-cycle strobe at 4096 Hz |
| tick_64 | input | 1 | One-cycle strobe at 64 Hz |
| tick_sec | input | 1 | One-cycle strobe each second |
| tick_min | input | 1 | One-cycle strobe each minute |
| tmr_en | input | 1 | Timer run enable |
| tmr_src | input | 2 | Timer strobe select |
| tmr_reload | input | 12 | Timer reload value |
| tmr_ie | input | 1 | Timer interrupt enable |
| upd_min_mode | input | 1 | Update period: 0 second, 1 minute |
| upd_ie | input | 1 | Update interrupt enable |
| alm_ie | input | 1 | Alarm interrupt enable |
| alm_min | input | 7 | Alarm minute |
| alm_hour | input | 6 | Alarm hour |
| alm_day | input | 6 | Alarm date or weekday |
| alm_min_en | input | 1 | Compare minute |
| alm_hour_en | input | 1 | Compare hour |
| alm_day_en | input | 1 | Compare day |
| alm_wday_mode | input | 1 | Day field compares weekday |
| cal_min | input | 7 | Calendar minute |
| cal_hour | input | 6 | Calendar hour |
| cal_date | input | 6 | Calendar date |
| cal_wday | input | 3 | Calendar weekday |
| clr_tf | input | 1 | Clear timer flag |
| clr_uf | input | 1 | Clear update flag |
| clr_af | input | 1 | Clear alarm flag |
| tf_flag | output | 1 | Timer flag |
| uf_flag | output | 1 | Update flag |
| af_flag | output | 1 | Alarm flag |
| int_low | output | 1 | 1 pulls the interrupt pin low |

## Verification
The hardest situation to reach is overlap. This means a new timer or update event arriving while an earlier pulse is still counting down, or while an alarm is holding the line, or in the same cycle as a flag clear. The bench reaches it by running all four strobes at once with unrelated short periods. Timer reloads are kept small and the calendar is confined to a few values so that alarm matches recur. Clear strobes are scattered at random. A cycle-level reference model is compared on every clock, so every coincidence that arises is checked.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    typedef enum logic [1:0] {
        SRC_4K  = 2'd0,
        SRC_64  = 2'd1,
        SRC_SEC = 2'd2,
        SRC_MIN = 2'd3
    } tmr_src_e;

    localparam int NUM_SRC = 3;
    localparam int IDX_TMR = 0;
    localparam int IDX_UPD = 1;
    localparam int IDX_ALM = 2;
endpackage

// File: rtl/rtc_irq_timer.sv
module rtc_irq_timer
    import rtc_irq_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  tmr_src_e         src,
    input  logic [3:0]       ticks,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       tick_sel;

    always_comb begin
        tick_sel = ticks[src];
        expire   = en && tick_sel && (st_q.cnt <= CNT_W'(1));
        st_d     = st_q;
        if (!en) begin
            st_d.cnt = reload;
        end else if (tick_sel) begin
            if (expire) st_d.cnt = reload;
            else        st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtc_irq_alarm.sv
module rtc_irq_alarm #(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int DAY_W  = 6,
    parameter int WDAY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MIN_W-1:0]  alm_min,
    input  logic [HOUR_W-1:0] alm_hour,
    input  logic [DAY_W-1:0]  alm_day,
    input  logic              min_en,
    input  logic              hour_en,
    input  logic              day_en,
    input  logic              wday_mode,
    input  logic [MIN_W-1:0]  cal_min,
    input  logic [HOUR_W-1:0] cal_hour,
    input  logic [DAY_W-1:0]  cal_date,
    input  logic [WDAY_W-1:0] cal_wday,
    output logic              hit
);
    localparam int NFIELD = 3;

    typedef struct packed {
        logic match;
    } alm_state_t;

    alm_state_t        st_d, st_q;
    logic [NFIELD-1:0] fld_en, fld_eq, fld_ok;
    logic              day_eq, match_now;

    always_comb begin
        day_eq = wday_mode ? (alm_day[WDAY_W-1:0] == cal_wday) : (alm_day == cal_date);
        fld_en = {day_en, hour_en, min_en};
        fld_eq = {day_eq, alm_hour == cal_hour, alm_min == cal_min};
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        assign fld_ok[g] = !fld_en[g] || fld_eq[g];
    end

    always_comb begin
        match_now  = (|fld_en) && (&fld_ok);
        hit        = match_now && !st_q.match;
        st_d       = st_q;
        st_d.match = match_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtc_irq_pulse.sv
module rtc_irq_pulse #(
    parameter int PULSE_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic active
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pls_state_t;

    pls_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        active = (st_q.left != '0);
        if (start)              st_d.left = PW'(PULSE_TICKS);
        else if (tick && active) st_d.left = st_q.left - PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int RELOAD_W    = 12,
    parameter int PULSE_TICKS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_4k,
    input  logic                tick_64,
    input  logic                tick_sec,
    input  logic                tick_min,
    input  logic                tmr_en,
    input  logic [1:0]          tmr_src,
    input  logic [RELOAD_W-1:0] tmr_reload,
    input  logic                tmr_ie,
    input  logic                upd_min_mode,
    input  logic                upd_ie,
    input  logic                alm_ie,
    input  logic [6:0]          alm_min,
    input  logic [5:0]          alm_hour,
    input  logic [5:0]          alm_day,
    input  logic                alm_min_en,
    input  logic                alm_hour_en,
    input  logic                alm_day_en,
    input  logic                alm_wday_mode,
    input  logic [6:0]          cal_min,
    input  logic [5:0]          cal_hour,
    input  logic [5:0]          cal_date,
    input  logic [2:0]          cal_wday,
    input  logic                clr_tf,
    input  logic                clr_uf,
    input  logic                clr_af,
    output logic                tf_flag,
    output logic                uf_flag,
    output logic                af_flag,
    output logic                int_low
);
    logic               tmr_evt, upd_evt, alm_evt, pulse_start, pulse_on;
    logic [NUM_SRC-1:0] fl_set, fl_clr, fl_q;

    rtc_irq_timer #(.CNT_W(RELOAD_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tmr_en),
        .src    (tmr_src_e'(tmr_src)),
        .ticks  ({tick_min, tick_sec, tick_64, tick_4k}),
        .reload (tmr_reload),
        .expire (tmr_evt)
    );

    rtc_irq_alarm u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .alm_min   (alm_min),
        .alm_hour  (alm_hour),
        .alm_day   (alm_day),
        .min_en    (alm_min_en),
        .hour_en   (alm_hour_en),
        .day_en    (alm_day_en),
        .wday_mode (alm_wday_mode),
        .cal_min   (cal_min),
        .cal_hour  (cal_hour),
        .cal_date  (cal_date),
        .cal_wday  (cal_wday),
        .hit       (alm_evt)
    );

    always_comb begin
        upd_evt     = upd_min_mode ? tick_min : tick_sec;
        pulse_start = (tmr_evt && tmr_ie) || (upd_evt && upd_ie);
        fl_set      = '0;
        fl_clr      = '0;
        fl_set[IDX_TMR] = tmr_evt;
        fl_set[IDX_UPD] = upd_evt;
        fl_set[IDX_ALM] = alm_evt;
        fl_clr[IDX_TMR] = clr_tf;
        fl_clr[IDX_UPD] = clr_uf;
        fl_clr[IDX_ALM] = clr_af;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        logic flag_d, flag_q;
        always_comb begin
            flag_d = flag_q;
            if (fl_clr[g]) flag_d = 1'b0;
            if (fl_set[g]) flag_d = 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= flag_d;
        end
        assign fl_q[g] = flag_q;
    end

    rtc_irq_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pulse_start),
        .tick   (tick_4k),
        .active (pulse_on)
    );

    assign tf_flag = fl_q[IDX_TMR];
    assign uf_flag = fl_q[IDX_UPD];
    assign af_flag = fl_q[IDX_ALM];
    assign int_low = pulse_on || (fl_q[IDX_ALM] && alm_ie);
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tmr_evt,
    input logic upd_evt,
    input logic tmr_ie,
    input logic upd_ie,
    input logic alm_ie,
    input logic clr_tf,
    input logic clr_uf,
    input logic clr_af,
    input logic tf_flag,
    input logic uf_flag,
    input logic af_flag,
    input logic int_low
);
    assert_tmr_sets_tf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt |=> tf_flag);

    assert_upd_sets_uf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> uf_flag);

    assert_tf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_flag && !clr_tf) |=> tf_flag);

    assert_uf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !clr_uf) |=> uf_flag);

    assert_af_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (af_flag && !clr_af) |=> af_flag);

    assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmr_evt && tmr_ie) || (upd_evt && upd_ie)) |=> int_low);

    assert_alarm_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (af_flag && alm_ie) |-> int_low);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_evt (tmr_evt),
    .upd_evt (upd_evt),
    .tmr_ie  (tmr_ie),
    .upd_ie  (upd_ie),
    .alm_ie  (alm_ie),
    .clr_tf  (clr_tf),
    .clr_uf  (clr_uf),
    .clr_af  (clr_af),
    .tf_flag (tf_flag),
    .uf_flag (uf_flag),
    .af_flag (af_flag),
    .int_low (int_low)
);

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb_top;
    localparam int PT = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_4k = 0, tick_64 = 0, tick_sec = 0, tick_min = 0;
    logic tmr_en = 0, tmr_ie = 0, upd_min_mode = 0, upd_ie = 0, alm_ie = 0;
    logic [1:0]  tmr_src = 0;
    logic [11:0] tmr_reload = 0;
    logic [6:0]  alm_min = 0, cal_min = 0;
    logic [5:0]  alm_hour = 0, alm_day = 0, cal_hour = 0, cal_date = 0;
    logic [2:0]  cal_wday = 0;
    logic alm_min_en = 0, alm_hour_en = 0, alm_day_en = 0, alm_wday_mode = 0;
    logic clr_tf = 0, clr_uf = 0, clr_af = 0;
    logic tf_flag, uf_flag, af_flag, int_low;

    int n_cmp = 0, n_bad = 0, cyc = 0, wd = 0;
    bit done = 0;
    int tf_rises = 0, uf_rises = 0, af_rises = 0;

    always #2 clk = ~clk;

    rtc_irq_ctrl #(.RELOAD_W(12), .PULSE_TICKS(PT)) dut_i (.*);

    // behavioural reference
    int m_cnt, m_pulse;
    bit m_tf, m_uf, m_af, m_prev;
    always @(posedge clk) begin
        bit tk, et, eu, ea, mt;
        if (!rst_n) begin
            m_cnt = 0; m_pulse = 0; m_tf = 0; m_uf = 0; m_af = 0; m_prev = 0;
        end else begin
            case (tmr_src)
                2'd0: tk = tick_4k;
                2'd1: tk = tick_64;
                2'd2: tk = tick_sec;
                default: tk = tick_min;
            endcase
            et = 0;
            if (!tmr_en) m_cnt = tmr_reload;
            else if (tk) begin
                if (m_cnt <= 1) begin et = 1; m_cnt = tmr_reload; end
                else m_cnt = m_cnt - 1;
            end
            eu = upd_min_mode ? tick_min : tick_sec;
            mt = (alm_min_en || alm_hour_en || alm_day_en)
               && (!alm_min_en || alm_min == cal_min)
               && (!alm_hour_en || alm_hour == cal_hour)
               && (!alm_day_en || (alm_wday_mode ? alm_day[2:0] == cal_wday : alm_day == cal_date));
            ea = mt && !m_prev;
            m_prev = mt;
            if (clr_tf) m_tf = 0;
            if (et) m_tf = 1;
            if (clr_uf) m_uf = 0;
            if (eu) m_uf = 1;
            if (clr_af) m_af = 0;
            if (ea) m_af = 1;
            if ((et && tmr_ie) || (eu && upd_ie)) m_pulse = PT;
            else if (tick_4k && m_pulse > 0) m_pulse = m_pulse - 1;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        bit prev_tf = tf_flag;
        chk("R2/R3 tf_flag", tf_flag, m_tf);
        chk("R4 uf_flag", uf_flag, m_uf);
        chk("R5 af_flag", af_flag, m_af);
        chk("R7/R8/R9 int_low", int_low, (m_pulse > 0) || (m_af && alm_ie));
        if (prev_tf) begin end
    endtask

    bit p_tf = 0, p_uf = 0, p_af = 0;
    task automatic run(int n, int clr_rate);
        for (int i = 0; i < n; i++) begin
            cyc++;
            tick_4k  = (cyc % 3) == 0;
            tick_64  = (cyc % 11) == 0;
            tick_sec = (cyc % 29) == 0;
            tick_min = (cyc % 97) == 0;
            if ((cyc % 7) == 0) begin
                cal_min  = 7'($urandom_range(0, 3));
                cal_hour = 6'($urandom_range(0, 1));
                cal_date = 6'($urandom_range(0, 2));
                cal_wday = 3'($urandom_range(0, 2));
            end
            clr_tf = clr_rate != 0 && ($urandom % clr_rate) == 0;
            clr_uf = clr_rate != 0 && ($urandom % clr_rate) == 0;
            clr_af = clr_rate != 0 && ($urandom % clr_rate) == 0;
            @(posedge clk);
            @(negedge clk);
            compare_all();
            if (tf_flag && !p_tf) tf_rises++;
            if (uf_flag && !p_uf) uf_rises++;
            if (af_flag && !p_af) af_rises++;
            p_tf = tf_flag; p_uf = uf_flag; p_af = af_flag;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tf_flag reset", tf_flag, 1'b0);
        chk("R1 uf_flag reset", uf_flag, 1'b0);
        chk("R1 af_flag reset", af_flag, 1'b0);
        chk("R1 int_low reset", int_low, 1'b0);
        rst_n = 1'b1;

        // R2/R3: timer on 4k strobe, reload 5, interrupt on
        tmr_en = 1; tmr_src = 2'd0; tmr_reload = 12'd5; tmr_ie = 1;
        run(400, 60);
        // R2: 64 Hz source, reload 2, interrupt off (R8)
        tmr_src = 2'd1; tmr_reload = 12'd2; tmr_ie = 0;
        run(400, 50);
        // R2: second source, reload 0 behaves as 1
        tmr_src = 2'd2; tmr_reload = 12'd0; tmr_ie = 1;
        run(400, 40);
        // R2: minute source, reload 3
        tmr_src = 2'd3; tmr_reload = 12'd3;
        run(800, 0);
        // R2: disabled timer must not expire, reload changes absorbed
        tmr_en = 0; tmr_src = 2'd0; tmr_reload = 12'd1;
        run(300, 20);
        tmr_en = 1;
        run(50, 0);
        tmr_en = 0;

        // R4/R7: update per second with interrupt, then per minute
        upd_ie = 1; upd_min_mode = 0;
        run(500, 45);
        upd_min_mode = 1;
        run(600, 45);
        upd_ie = 0; upd_min_mode = 0;   // R8
        run(300, 30);

        // R5/R9: alarm on minute+hour, date mode
        alm_min = 7'd2; alm_hour = 6'd1; alm_day = 6'd1;
        alm_min_en = 1; alm_hour_en = 1; alm_ie = 1;
        run(600, 80);
        // weekday mode with day compare only
        alm_min_en = 0; alm_hour_en = 0; alm_day_en = 1; alm_wday_mode = 1; alm_day = 6'd2;
        run(600, 80);
        // date mode, alarm interrupt off
        alm_wday_mode = 0; alm_ie = 0;
        run(400, 60);
        // R5: no field enabled never matches
        alm_day_en = 0; alm_ie = 1;
        clr_af = 1; @(posedge clk); @(negedge clk); clr_af = 0; cyc++; compare_all();
        run(400, 0);
        chk("R5 af_flag stays 0 with no fields", af_flag, 1'b0);

        // all sources at once: overlap of pulses, alarm and clears (R6/R7)
        tmr_en = 1; tmr_src = 2'd0; tmr_reload = 12'd40; tmr_ie = 1;
        upd_ie = 1; alm_min_en = 1; alm_min = 7'd1;
        run(2000, 25);

        chk("R3 timer flag observed rising", tf_rises > 0, 1'b1);
        chk("R4 update flag observed rising", uf_rises > 0, 1'b1);
        chk("R5 alarm flag observed rising", af_rises > 0, 1'b1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule